// File: doc/BRIEF.md
# Quadrature Position Counter with Direction Flip-Flops

This block turns the two square-wave channels of an incremental rotary encoder into an 11-bit angular position, 2048 counts per turn, with wrap-around. Direction is not found with a state table. Two small set/clear flip-flops do that job instead. The forward flip-flop is set by a rising edge of channel A and is forced clear while channel B is high. The reverse flip-flop is the mirror image: it is set by a rising edge of channel B and forced clear while channel A is high. Each flip-flop's rising output advances its own up-only counter. The position is the forward count minus the reverse count.

Both channels are asynchronous. Each passes through a synchronizer. All edges are then detected on the system clock by comparing each sampled level with the level from the cycle before. A consumer asks for a reading by pulsing a snapshot strobe. Both counters are captured on the same clock edge, so the difference is formed from a consistent pair. One clock later the position output carries the new value and a valid flag pulses for that cycle. Between strobes the position output holds its last value.

Top module: `qenc_flop_position`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the cycle after it is released, the position output is 0 and the valid flag is 0. Reset also clears both flip-flops and both counters.
- R2: One full forward quadrature cycle adds 1 to the position. A forward cycle is channel levels (A,B) = 00, 10, 11, 01, 00.
- R3: One full reverse quadrature cycle subtracts 1 from the position. A reverse cycle is (A,B) = 00, 01, 11, 10, 00.
- R4: Clear wins over set:
  - A rising edge of A that arrives while B is high is ignored.
  - A rising edge of B that arrives while A is high is ignored.
  - Both channels rising in the same cycle produce no count.
- R5: Once a flip-flop is set, further rising edges on its channel add nothing until the flip-flop has been cleared. Contact bounce on A with B low therefore counts once.
- R6: The position is (forward count − reverse count) modulo 2048. Counting below zero wraps to 2047 and downward.
- R7: The position output changes only in the cycle after a snapshot strobe. The valid flag is 1 in exactly that cycle and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chA | input | 1 | Encoder channel A, asynchronous |
| chB | input | 1 | Encoder channel B, asynchronous |
| snapReq | input | 1 | Snapshot strobe, one clock wide |
| position | output | 11 | Latched position, forward minus reverse, modulo 2048 |
| posValid | output | 1 | One-clock pulse when position has just been updated |

## Verification
The bench drives both channels rising together and drives A rising while B is already high. A design that let set win over clear would count in those cases and drift away from zero. It bounces A several times with B low. A design that counted channel edges instead of flip-flop edges would add one count per bounce. It also runs the count backwards through zero to show the 11-bit wrap to 2045. Finally, it moves the encoder without strobing and checks that the position stays put. A design that let the output track the counters would show the new count early, with no valid pulse.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic incFwd;   // forward flip-flop rose
    logic incRev;   // reverse flip-flop rose
    logic capture;  // take snapshot of both counters
  } qenc_strobe_t;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/qenc_edge_flop.sv
module qenc_edge_flop (
  input  logic clk,
  input  logic rst,
  input  logic setLvl,   // sampled level whose rising edge sets
  input  logic clrLvl,   // sampled level that holds clear
  output logic flopQ,
  output logic incPulse
);
  logic prevSet;
  logic prevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevSet <= 1'b0;
      prevQ   <= 1'b0;
      flopQ   <= 1'b0;
    end else begin
      prevSet <= setLvl;
      prevQ   <= flopQ;
      if (clrLvl)                  flopQ <= 1'b0;  // clear has priority
      else if (setLvl && !prevSet) flopQ <= 1'b1;
    end
  end

  assign incPulse = flopQ & ~prevQ;
endmodule

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chA,
  input  logic         chB,
  input  logic         snapReq,
  output qenc_strobe_t strobes,
  output logic         aLvl,
  output logic         bLvl,
  output logic         fwdFlop,
  output logic         revFlop
);
  localparam int NCH = 2;

  logic [NCH-1:0] rawIn;
  logic [NCH-1:0] lvl;
  logic [NCH-1:0] flopQ;
  logic [NCH-1:0] inc;

  assign rawIn = {chB, chA};

  // Index 0 = forward (set by A, cleared by B); 1 = reverse (set by B, cleared by A)
  for (genvar d = 0; d < NCH; d++) begin : g_dir
    qenc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(rawIn[d]), .dout(lvl[d])
    );
    qenc_edge_flop u_flop (
      .clk(clk), .rst(rst),
      .setLvl(lvl[d]), .clrLvl(lvl[NCH-1-d]),
      .flopQ(flopQ[d]), .incPulse(inc[d])
    );
  end

  assign strobes.incFwd  = inc[0];
  assign strobes.incRev  = inc[1];
  assign strobes.capture = snapReq;
  assign aLvl    = lvl[0];
  assign bLvl    = lvl[1];
  assign fwdFlop = flopQ[0];
  assign revFlop = flopQ[1];
endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int FWD_W = 16,
  parameter int REV_W = 24,
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  qenc_strobe_t     strobes,
  output logic [POS_W-1:0] position,
  output logic             posValid
);
  logic [FWD_W-1:0] fwdCnt;
  logic [REV_W-1:0] revCnt;
  logic [POS_W-1:0] snapFwd;
  logic [POS_W-1:0] snapRev;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwdCnt <= '0;
      revCnt <= '0;
    end else begin
      if (strobes.incFwd) fwdCnt <= fwdCnt + 1'b1;
      if (strobes.incRev) revCnt <= revCnt + 1'b1;
    end
  end

  // Both counters captured on the same edge; only low bits reach the result
  always_ff @(posedge clk) begin
    if (rst) begin
      snapFwd  <= '0;
      snapRev  <= '0;
      posValid <= 1'b0;
    end else begin
      posValid <= strobes.capture;
      if (strobes.capture) begin
        snapFwd <= fwdCnt[POS_W-1:0];
        snapRev <= revCnt[POS_W-1:0];
      end
    end
  end

  assign position = snapFwd - snapRev;
endmodule

// File: rtl/qenc_flop_position.sv
module qenc_flop_position
  import qenc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FWD_W       = 16,
  parameter int REV_W       = 24,
  parameter int POS_W       = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chA,
  input  logic             chB,
  input  logic             snapReq,
  output logic [POS_W-1:0] position,
  output logic             posValid
);
  qenc_strobe_t strobes;
  logic aLvl;
  logic bLvl;
  logic fwdFlop;
  logic revFlop;

  qenc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .chA(chA), .chB(chB), .snapReq(snapReq),
    .strobes(strobes), .aLvl(aLvl), .bLvl(bLvl),
    .fwdFlop(fwdFlop), .revFlop(revFlop)
  );

  qenc_datapath #(.FWD_W(FWD_W), .REV_W(REV_W), .POS_W(POS_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .position(position), .posValid(posValid)
  );
endmodule

// File: rtl/qenc_flop_position_chk.sv
module qenc_flop_position_chk
  import qenc_pkg::*;
#(
  parameter int POS_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             snapReq,
  input logic [POS_W-1:0] position,
  input logic             posValid,
  input qenc_strobe_t     strobes,
  input logic             aLvl,
  input logic             bLvl,
  input logic             fwdFlop,
  input logic             revFlop
);
  // R1: reset leaves a zero, invalid output
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (position == '0 && !posValid));

  // R4: forward flop cleared whenever B was high
  p_fwd_clear_r4: assert property (@(posedge clk) disable iff (rst)
    bLvl |=> !fwdFlop);

  // R4: reverse flop cleared whenever A was high
  p_rev_clear_r4: assert property (@(posedge clk) disable iff (rst)
    aLvl |=> !revFlop);

  // R5: each direction increments at most once per flop rise
  p_single_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    strobes.incFwd |=> !strobes.incFwd);
  p_single_rev_r5: assert property (@(posedge clk) disable iff (rst)
    strobes.incRev |=> !strobes.incRev);

  // R7: valid follows a strobe
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    snapReq |=> posValid);

  // R7: output holds without a strobe
  p_pos_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !snapReq |=> ($stable(position) && !posValid));
endmodule

bind qenc_flop_position qenc_flop_position_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .snapReq(snapReq), .position(position),
  .posValid(posValid), .strobes(strobes), .aLvl(aLvl), .bLvl(bLvl),
  .fwdFlop(fwdFlop), .revFlop(revFlop)
);

// File: tb/qenc_flop_position_bench.sv
module qenc_flop_position_bench;
  localparam int POS_W = 11;
  localparam int MOD   = 1 << POS_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chA = 1'b0;
  logic chB = 1'b0;
  logic snapReq = 1'b0;
  logic [POS_W-1:0] position;
  logic posValid;

  int checks = 0;
  int fails  = 0;
  int expPos = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  qenc_flop_position u_qenc_flop_position (
    .clk(clk), .rst(rst), .chA(chA), .chB(chB), .snapReq(snapReq),
    .position(position), .posValid(posValid)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Set both channel levels, then let them settle through sync and flops
  task automatic step(input logic a, input logic b);
    @(negedge clk);
    chA = a;
    chB = b;
    repeat (6) @(negedge clk);
  endtask

  task automatic fwdCycle();
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    expPos = (expPos + 1) % MOD;
  endtask

  task automatic revCycle();
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    expPos = (expPos + MOD - 1) % MOD;
  endtask

  // Strobe, then check the update and the one-cycle valid pulse
  task automatic snapCheck(input string tag);
    @(negedge clk);
    snapReq = 1'b1;
    @(negedge clk);
    snapReq = 1'b0;
    check({tag, " valid"}, int'(posValid), 1);
    check({tag, " position"}, int'(position), expPos);
    @(negedge clk);
    check({tag, " valid drop R7"}, int'(posValid), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 position in reset", int'(position), 0);
    check("R1 valid in reset", int'(posValid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 position after release", int'(position), 0);
    expPos = 0;
  endtask

  task automatic t_forward();
    for (int i = 0; i < 5; i++) fwdCycle();
    snapCheck("R2 forward x5");
  endtask

  task automatic t_reverse();
    for (int i = 0; i < 3; i++) revCycle();
    snapCheck("R3 reverse x3");
  endtask

  task automatic t_hold();
    fwdCycle();
    fwdCycle();
    check("R7 held position", int'(position), (expPos + MOD - 2) % MOD);
    check("R7 no valid without strobe", int'(posValid), 0);
    snapCheck("R7 after strobe");
  endtask

  task automatic t_clear_priority();
    step(1, 1);  // both rise together
    step(0, 1);
    step(1, 1);  // A rises while B high
    step(0, 0);
    snapCheck("R4 clear wins");
  endtask

  task automatic t_bounce();
    step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0);
    expPos = (expPos + 1) % MOD;
    snapCheck("R5 A bounce counts once");
    step(0, 1); step(0, 0); step(0, 1); step(0, 0);
    expPos = (expPos + MOD - 1) % MOD;
    snapCheck("R5 B bounce counts once");
  endtask

  task automatic t_wrap();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    expPos = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) revCycle();
    snapCheck("R6 wrap below zero");
    check("R6 value 2045", int'(position), 2045);
    for (int i = 0; i < 5; i++) fwdCycle();
    snapCheck("R6 wrap back up");
  endtask

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_hold();
    t_clear_priority();
    t_bounce();
    t_wrap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule